// File: doc/BRIEF.md
# Program-Counter Trace Ring with Snapshot Readout

This block keeps the last eight program-counter values that the core reports, in a small ring. A live write pointer names the slot for the next capture and moves forward on every capture strobe. The ring can be unloaded from the debug side without touching that live pointer. A separate readout pointer is copied from the live pointer at the moment the debug register-select code switches to the trace-ring code.

Each debug read returns the slot at the readout pointer one cycle later and then moves the pointer forward by one slot. A full pass of eight reads therefore walks the whole ring from the oldest value to the newest and leaves the readout pointer back where it began. Either of two resets, a test reset or a power-on reset, clears both pointers, the stored values and the read data.

Top module: `pc_trace_snap`

## Requirements
- R1: While `test_rst` or `por_rst` is high at a clock edge, the live pointer, the readout pointer, every stored slot and `rd_data` are cleared to zero.
- R2: When `cap_valid` is high at a clock edge, `cap_pc` is written into the slot named by the live pointer, and the live pointer advances by one, wrapping from slot 7 to slot 0.
- R3: When `rd_en` is high at a clock edge, `rd_data` shows the addressed slot from the following cycle on; without `rd_en`, `rd_data` keeps its value, even when captures occur.
- R4: Every read advances the readout pointer by one slot modulo eight, so the ninth read of an unbroken run returns the same slot as the first.
- R5: The readout pointer is loaded from the live pointer at a clock edge where `reg_sel` equals 7'b0101101 and its value at the previous edge was different, including the first edge after reset.
- R6: While `reg_sel` stays at 7'b0101101 across edges, the readout pointer is not reloaded.
- R7: Reads never move the live pointer; captures that follow reads fill the slots they would have filled with no reads.
- R8: When a capture and a select transition fall on the same edge, the readout pointer takes the live pointer value from before that capture.
- R9: When a read falls on the same edge as a select transition, the read is served from the freshly loaded pointer, which then advances by one.
- R10: When a read and a capture address the same slot on the same edge, the read returns the slot content from before the capture.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| test_rst | input | 1 | Synchronous active-high test reset |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| cap_valid | input | 1 | Capture strobe for `cap_pc` |
| cap_pc | input | 32 | Program-counter value to record |
| reg_sel | input | 7 | Debug register-select code; 7'b0101101 selects the trace ring |
| rd_en | input | 1 | Debug read strobe |
| rd_data | output | 32 | Registered read data |

## Verification
A readout pointer loaded from the wrong place shows at once as the first read after a select transition returning a slot other than the oldest, and a pointer that fails to advance shows as the same value returned twice in a row. A live pointer disturbed by reads only becomes visible later, when a following full pass of eight reads puts the newest capture in the wrong position, so the bench captures after reads and then reads a whole pass. Same-edge collisions of capture, select and read are each driven so that the old and new interpretations return different data on the very next cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int DEPTH = 8;
    localparam int PC_W  = 32;
    localparam int SEL_W = 7;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    localparam logic [SEL_W-1:0] TRACE_SEL = 7'b0101101;

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic wr;
        ptr_t waddr;
        pc_t  wdata;
        logic rd;
        ptr_t raddr;
    } ring_req_t;

    function automatic ptr_t ptr_next(input ptr_t p);
        if (p == ptr_t'(DEPTH - 1))
            return '0;
        return p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/trc_ptr_ctrl.sv
module trc_ptr_ctrl
    import trc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_valid,
    input  sel_t reg_sel,
    input  logic rd_en,
    output ptr_t live_ptr,
    output ptr_t rd_addr
);

    ptr_t tmp_ptr;
    sel_t sel_q;
    logic sel_hit;

    assign sel_hit = (reg_sel == TRACE_SEL) && (sel_q != TRACE_SEL);
    assign rd_addr = sel_hit ? live_ptr : tmp_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_ptr <= '0;
            tmp_ptr  <= '0;
            sel_q    <= '0;
        end else begin
            sel_q <= reg_sel;
            if (cap_valid)
                live_ptr <= ptr_next(live_ptr);
            if (sel_hit || rd_en)
                tmp_ptr <= rd_en ? ptr_next(rd_addr) : rd_addr;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (live_ptr == '0 && tmp_ptr == '0));

    assert_capture_steps_R2: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> live_ptr == ptr_next($past(live_ptr)));

    assert_read_keeps_live_R7: assert property (@(posedge clk) disable iff (rst)
        !cap_valid |=> $stable(live_ptr));

    assert_read_steps_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel_hit) |=> tmp_ptr == ptr_next($past(tmp_ptr)));

    assert_snapshot_pre_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_hit && !rd_en) |=> tmp_ptr == $past(live_ptr));

    assert_select_read_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_hit && rd_en) |=> tmp_ptr == ptr_next($past(live_ptr)));

    assert_hold_no_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_q == TRACE_SEL && !rd_en) |=> $stable(tmp_ptr));

endmodule

// File: rtl/trc_store.sv
module trc_store
    import trc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ring_req_t req,
    output pc_t       rdata
);

    pc_t slots [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[gi] <= '0;
            else if (req.wr && req.waddr == ptr_t'(gi))
                slots[gi] <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req.rd)
            rdata <= slots[req.raddr];
    end

endmodule

// File: rtl/pc_trace_snap.sv
module pc_trace_snap
    import trc_pkg::*;
(
    input  logic             clk,
    input  logic             test_rst,
    input  logic             por_rst,
    input  logic             cap_valid,
    input  logic [PC_W-1:0]  cap_pc,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             rd_en,
    output logic [PC_W-1:0]  rd_data
);

    logic      any_rst;
    ptr_t      live_ptr;
    ptr_t      rd_addr;
    ring_req_t req;

    assign any_rst = test_rst | por_rst;

    trc_ptr_ctrl u_ptr (
        .clk      (clk),
        .rst      (any_rst),
        .cap_valid(cap_valid),
        .reg_sel  (reg_sel),
        .rd_en    (rd_en),
        .live_ptr (live_ptr),
        .rd_addr  (rd_addr)
    );

    always_comb begin
        req.wr    = cap_valid;
        req.waddr = live_ptr;
        req.wdata = cap_pc;
        req.rd    = rd_en;
        req.raddr = rd_addr;
    end

    trc_store u_store (
        .clk  (clk),
        .rst  (any_rst),
        .req  (req),
        .rdata(rd_data)
    );

    assert_data_reset_R1: assert property (@(posedge clk)
        any_rst |=> rd_data == '0);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (any_rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/pc_trace_snap_test.sv
module pc_trace_snap_test;

    localparam logic [6:0] SEL_T = 7'b0101101;
    localparam logic [6:0] SEL_N = 7'h00;

    typedef struct packed {
        logic        cap;
        logic [31:0] pc;
        logic [6:0]  sel;
        logic        rd;
        logic        chk;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 32'h100, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h101, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h102, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h103, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h104, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h105, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h106, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h107, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h108, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h109, SEL_N, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0,   SEL_T, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h102},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h103},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h104},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h105},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h106},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h107},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h108},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h109},
        '{1'b0, 32'h0,   SEL_T, 1'b1, 1'b1, 32'h102}
    };

    logic        clk = 1'b0;
    logic        test_rst = 1'b0;
    logic        por_rst = 1'b1;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_pc = '0;
    logic [6:0]  reg_sel = SEL_N;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pc_trace_snap uut (
        .clk      (clk),
        .test_rst (test_rst),
        .por_rst  (por_rst),
        .cap_valid(cap_valid),
        .cap_pc   (cap_pc),
        .reg_sel  (reg_sel),
        .rd_en    (rd_en),
        .rd_data  (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic [31:0] pc, input logic [6:0] s, input logic r);
        cap_valid = c;
        cap_pc    = pc;
        reg_sel   = s;
        rd_en     = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        check("R1 reset read data", rd_data, 32'h0);

        // R2 captures, R5 select load, R4 and R6 read pass with wrap
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].cap, TBL[i].pc, TBL[i].sel, TBL[i].rd);
            if (TBL[i].chk)
                check("R2/R4/R6 table read", rd_data, TBL[i].exp);
        end
        step(1'b0, 32'h0, SEL_T, 1'b0);
        check("R3 hold without read", rd_data, 32'h102);

        // R1 power-on reset clears pointers and data
        por_rst = 1'b1;
        step(1'b0, 32'h0, SEL_N, 1'b0);
        por_rst = 1'b0;
        check("R1 por clears data", rd_data, 32'h0);
        step(1'b0, 32'h0, SEL_T, 1'b0);
        step(1'b1, 32'hA0, SEL_T, 1'b0);
        step(1'b0, 32'h0, SEL_T, 1'b1);
        check("R1 pointers at zero", rd_data, 32'hA0);

        // R7 reads leave the live pointer alone
        step(1'b0, 32'h0, SEL_T, 1'b1);
        step(1'b0, 32'h0, SEL_T, 1'b1);
        step(1'b1, 32'hB0, SEL_T, 1'b0);
        step(1'b0, 32'h0, SEL_N, 1'b0);
        step(1'b0, 32'h0, SEL_T, 1'b0);
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 32'h0, SEL_T, 1'b1);
            if (k == 6) check("R5/R7 reload then pass", rd_data, 32'hA0);
            if (k == 7) check("R7 newest after reads", rd_data, 32'hB0);
        end

        // R8 capture and select on one edge
        step(1'b0, 32'h0, SEL_N, 1'b0);
        step(1'b1, 32'hC0, SEL_T, 1'b0);
        step(1'b0, 32'h0, SEL_T, 1'b1);
        check("R8 pre-capture snapshot", rd_data, 32'hC0);

        // R9 read and select on one edge
        step(1'b1, 32'hE0, SEL_N, 1'b0);
        step(1'b1, 32'hE1, SEL_N, 1'b0);
        step(1'b1, 32'hE2, SEL_N, 1'b0);
        step(1'b1, 32'hE3, SEL_N, 1'b0);
        step(1'b1, 32'hE4, SEL_N, 1'b0);
        step(1'b0, 32'h0, SEL_T, 1'b1);
        check("R9 read on select edge", rd_data, 32'hA0);
        step(1'b0, 32'h0, SEL_T, 1'b1);
        check("R9 advance after select read", rd_data, 32'hB0);

        // R10 read and capture on the same slot
        step(1'b1, 32'hF0, SEL_T, 1'b0);
        step(1'b1, 32'hF1, SEL_T, 1'b0);
        step(1'b1, 32'hF2, SEL_T, 1'b1);
        check("R10 old content on collision", rd_data, 32'hC0);
        step(1'b0, 32'h0, SEL_T, 1'b1);
        check("R4 next slot", rd_data, 32'hE0);
        step(1'b1, 32'hF3, SEL_T, 1'b0);
        check("R3 hold across capture", rd_data, 32'hE0);

        // R1 test reset
        test_rst = 1'b1;
        step(1'b0, 32'h0, SEL_N, 1'b0);
        test_rst = 1'b0;
        check("R1 test reset clears data", rd_data, 32'h0);
        step(1'b0, 32'h0, SEL_T, 1'b0);
        step(1'b1, 32'h77, SEL_T, 1'b0);
        step(1'b0, 32'h0, SEL_T, 1'b1);
        check("R1 test reset pointers", rd_data, 32'h77);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule